// File: doc/BRIEF.md
# Paged Serial-EEPROM Storage Core

This block is the storage half of a byte-wide serial EEPROM model. A protocol engine that already handles bits, start and stop conditions drives it with single-cycle strobes: load a word address, hand over one received data byte, advance after a byte has been read out, and end a write sequence with a stop. The core holds an 8192 x 8 array arranged as 256 rows of 32 bytes, a 13-bit word address counter, a 32-slot row buffer with a valid flag per slot, and a self-timed write cycle that raises a busy flag.

Incoming write bytes only land in the row buffer, and the low five counter bits advance so that a long burst wraps inside its row. The array is updated only when a stop arrives and write protect is low. During the busy window that follows, one buffer slot is copied into the array per clock, and only flagged slots are copied. Reads present the byte at the counter with no wait, and each read advance moves the full 13-bit counter, wrapping from the top of the array to zero. The counter keeps its value between transactions.

Top module: `eeprom_store`

## Requirements
- R1: Strobes are taken on the rising clock edge. When several arrive in one cycle, address load wins over a data byte, and a data byte wins over a read advance. `rd_data_o` always shows the array byte at the current counter value.
- R2: Each accepted data byte increments only counter bits [4:0]. Bits [12:5] stay fixed, so offset 31 is followed by offset 0 of the same 32-byte row.
- R3: When more than 32 bytes arrive in one write sequence, a later byte that wraps onto an earlier offset replaces it. Only the last byte at each offset is committed.
- R4: A commit changes only the offsets that received a byte. Every other byte of the row keeps its old value.
- R5: Each read advance increments the full 13-bit counter, and address 0x1FFF is followed by 0x0000.
- R6: The counter holds its value between transactions. A read with no new address load returns the byte one past the last byte written or read.
- R7: A stop that ends a write sequence with write protect low and at least one buffered byte raises `busy_o` from the next cycle for exactly `WR_CYCLES` clocks. The committed bytes can be read once busy has dropped.
- R8: With `wp_i` high at the stop, nothing is committed and `busy_o` stays low. The data bytes still advance the counter.
- R9: A stop that follows no data byte starts no write cycle, and `busy_o` stays low.
- R10: While `busy_o` is high, every strobe (address load, data byte, read advance, stop) is ignored.
- R11: An address load discards all bytes buffered since the last stop, so only bytes received after the most recent load can be committed.
- R12: Reset clears the busy flag, empties the buffer and sets the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_i | input | 1 | Write protect, high blocks every commit |
| addr_load_i | input | 1 | Load the counter from `addr_i` |
| addr_i | input | ADDR_W | Word address to load |
| wr_byte_i | input | 1 | A complete data byte has been received |
| wr_data_i | input | DATA_W | The received data byte |
| rd_adv_i | input | 1 | A byte has been read out, so advance the counter |
| stop_wr_i | input | 1 | A stop has ended a write sequence |
| rd_data_o | output | DATA_W | Array byte at the current counter value |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A counter that steps the wrong bits shows up on the very next read: `rd_data_o` points at a neighbouring row or fails to wrap, which is visible one cycle after the strobe. Buffer flags that are stale or lost only show after the commit window closes, when a reread of the row returns bytes that were never sent or old bytes where new ones were expected. The bench therefore always rereads whole rows after a commit. A timer that counts wrong is visible at `busy_o` at the first or the last cycle of the window. A strobe leaking in during busy shows as a moved counter or a second busy window straight after the first.

// File: rtl/eeprom_store_pkg.sv
`timescale 1ns/1ps
package eeprom_store_pkg;

    localparam int DEF_ADDR_W = 13;
    localparam int DEF_OFF_W  = 5;
    localparam int DEF_DATA_W = 8;

    typedef enum logic [1:0] {
        ADV_NONE,
        ADV_LOAD,
        ADV_PAGE,
        ADV_LINEAR
    } adv_e;

    function automatic adv_e pick_adv(input logic ld, input logic wr, input logic rd);
        if (ld)      return ADV_LOAD;
        else if (wr) return ADV_PAGE;
        else if (rd) return ADV_LINEAR;
        else         return ADV_NONE;
    endfunction

endpackage

// File: rtl/eeprom_addr_ctr.sv
`timescale 1ns/1ps
module eeprom_addr_ctr
    import eeprom_store_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int OFF_W  = DEF_OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  adv_e              op,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            case (op)
                ADV_LOAD:   addr_q <= load_val;
                ADV_PAGE:   addr_q <= {addr_q[ADDR_W-1:OFF_W], addr_q[OFF_W-1:0] + 1'b1};
                ADV_LINEAR: addr_q <= addr_q + 1'b1;
                default:    addr_q <= addr_q;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_row_buf.sv
`timescale 1ns/1ps
module eeprom_row_buf #(
    parameter int OFF_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              any_valid
);

    localparam int SLOTS = 1 << OFF_W;

    logic [DATA_W-1:0] dat_q [SLOTS];
    logic              vld_q [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_off == OFF_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clr) vld_q[i] <= 1'b0;
            else if (hit)   vld_q[i] <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit) dat_q[i] <= wr_data;
        end
    end

    always_comb begin
        any_valid = 1'b0;
        for (int k = 0; k < SLOTS; k++) any_valid = any_valid | vld_q[k];
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_data  = dat_q[rd_idx];

endmodule

// File: rtl/eeprom_wr_timer.sv
`timescale 1ns/1ps
module eeprom_wr_timer #(
    parameter int CYCLES = 625000,
    parameter int OFF_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             slot_en,
    output logic [OFF_W-1:0] slot_idx,
    output logic             done
);

    localparam int SLOTS = 1 << OFF_W;
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (cnt_q == CNT_W'(CYCLES - 1)) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy     = busy_q;
    assign slot_en  = busy_q && (cnt_q < CNT_W'(SLOTS));
    assign slot_idx = cnt_q[OFF_W-1:0];
    assign done     = busy_q && (cnt_q == CNT_W'(CYCLES - 1));

endmodule

// File: rtl/eeprom_store.sv
`timescale 1ns/1ps
module eeprom_store
    import eeprom_store_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int OFF_W     = DEF_OFF_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int WR_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_byte_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_adv_i,
    input  logic              stop_wr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o
);

    localparam int WORDS = 1 << ADDR_W;
    localparam int ROW_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] cur_addr;
    logic              idle;
    adv_e              adv_op;
    logic              buf_wr, buf_clr, buf_any;
    logic              slot_vld;
    logic [DATA_W-1:0] slot_dat;
    logic              commit_go;
    logic              tmr_busy, tmr_slot_en, tmr_done;
    logic [OFF_W-1:0]  tmr_idx;
    logic [ROW_W-1:0]  row_q;
    logic [DATA_W-1:0] mem [WORDS];

    assign idle      = !tmr_busy;
    assign adv_op    = idle ? pick_adv(addr_load_i, wr_byte_i, rd_adv_i) : ADV_NONE;
    assign buf_wr    = (adv_op == ADV_PAGE);
    assign commit_go = idle && stop_wr_i && !addr_load_i && !wp_i && buf_any;
    assign buf_clr   = (idle && addr_load_i) || (idle && stop_wr_i && !commit_go) || tmr_done;

    eeprom_addr_ctr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .op       (adv_op),
        .load_val (addr_i),
        .addr_q   (cur_addr)
    );

    eeprom_row_buf #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clr       (buf_clr),
        .wr_en     (buf_wr),
        .wr_off    (cur_addr[OFF_W-1:0]),
        .wr_data   (wr_data_i),
        .rd_idx    (tmr_idx),
        .rd_valid  (slot_vld),
        .rd_data   (slot_dat),
        .any_valid (buf_any)
    );

    eeprom_wr_timer #(.CYCLES(WR_CYCLES), .OFF_W(OFF_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .start    (commit_go),
        .busy     (tmr_busy),
        .slot_en  (tmr_slot_en),
        .slot_idx (tmr_idx),
        .done     (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst)            row_q <= '0;
        else if (commit_go) row_q <= cur_addr[ADDR_W-1:OFF_W];
    end

    always_ff @(posedge clk) begin
        if (tmr_slot_en && slot_vld) mem[{row_q, tmr_idx}] <= slot_dat;
    end

    assign rd_data_o = mem[cur_addr];
    assign busy_o    = tmr_busy;

endmodule

// File: rtl/eeprom_store_chk.sv
`timescale 1ns/1ps
module eeprom_store_chk #(
    parameter int ADDR_W    = 13,
    parameter int OFF_W     = 5,
    parameter int WR_CYCLES = 625000
) (
    input logic              clk,
    input logic              rst,
    input logic              wp_i,
    input logic              addr_load_i,
    input logic              wr_byte_i,
    input logic              rd_adv_i,
    input logic              stop_wr_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] addr_q
);

    int unsigned busy_len;

    always_ff @(posedge clk) begin
        if (rst)         busy_len <= 0;
        else if (busy_o) busy_len <= busy_len + 1;
        else             busy_len <= 0;
    end

    // R7
    busy_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(stop_wr_i));

    // R7
    busy_length_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_len == WR_CYCLES));

    // R8
    wp_no_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_wr_i && wp_i && !busy_o) |=> !busy_o);

    // R10
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(addr_q));

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && wr_byte_i && !addr_load_i) |=>
            (addr_q[ADDR_W-1:OFF_W] == $past(addr_q[ADDR_W-1:OFF_W])));

    // R5
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && rd_adv_i && !wr_byte_i && !addr_load_i) |=>
            (addr_q == $past(addr_q) + 1'b1));

endmodule

bind eeprom_store eeprom_store_chk #(
    .ADDR_W    (ADDR_W),
    .OFF_W     (OFF_W),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wp_i        (wp_i),
    .addr_load_i (addr_load_i),
    .wr_byte_i   (wr_byte_i),
    .rd_adv_i    (rd_adv_i),
    .stop_wr_i   (stop_wr_i),
    .busy_o      (busy_o),
    .addr_q      (cur_addr)
);

// File: tb/tb_eeprom_store.sv
`timescale 1ns/1ps
module tb_eeprom_store;

    localparam int AW = 13;
    localparam int DW = 8;
    localparam int WR = 40;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wp_i = 1'b0;
    logic          addr_load_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          wr_byte_i = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic          rd_adv_i = 1'b0;
    logic          stop_wr_i = 1'b0;
    logic [DW-1:0] rd_data_o;
    logic          busy_o;

    int vectors = 0;
    int misses  = 0;

    logic [7:0] model [NW];
    logic [7:0] pend_d [32];
    bit         pend_v [32];
    int         exp_addr = 0;

    always #4 clk = ~clk;

    eeprom_store #(.WR_CYCLES(WR)) dut (
        .clk(clk), .rst(rst), .wp_i(wp_i),
        .addr_load_i(addr_load_i), .addr_i(addr_i),
        .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i),
        .rd_adv_i(rd_adv_i), .stop_wr_i(stop_wr_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o)
    );

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic clear_pend();
        for (int i = 0; i < 32; i++) pend_v[i] = 0;
    endtask

    task automatic do_load(input int a);
        addr_i = AW'(a); addr_load_i = 1'b1;
        @(negedge clk); addr_load_i = 1'b0;
        exp_addr = a;
        clear_pend();
    endtask

    task automatic do_byte(input logic [7:0] d);
        wr_data_i = d; wr_byte_i = 1'b1;
        @(negedge clk); wr_byte_i = 1'b0;
        pend_d[exp_addr & 31] = d;
        pend_v[exp_addr & 31] = 1;
        exp_addr = (exp_addr & 'h1FE0) | ((exp_addr + 1) & 'h1F);
    endtask

    task automatic do_adv();
        rd_adv_i = 1'b1;
        @(negedge clk); rd_adv_i = 1'b0;
        exp_addr = (exp_addr + 1) % NW;
    endtask

    // stop then wait out any commit; model updated only per R7/R8/R9
    task automatic do_stop_wait();
        bit any = 0;
        stop_wr_i = 1'b1;
        @(negedge clk); stop_wr_i = 1'b0;
        for (int i = 0; i < 32; i++) any |= pend_v[i];
        if (any && !wp_i)
            for (int i = 0; i < 32; i++)
                if (pend_v[i]) model[(exp_addr & 'h1FE0) | i] = pend_d[i];
        clear_pend();
        repeat (WR + 2) @(negedge clk);
    endtask

    task automatic read_run(input string tag, input int a, input int n);
        do_load(a);
        for (int i = 0; i < n; i++) begin
            chk8(tag, rd_data_o, model[exp_addr]);
            if (i != n - 1) do_adv();
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    // R12: reset state, counter at 0
    task automatic t_reset();
        chk1("R12 busy after reset", busy_o, 1'b0);
        exp_addr = 0;
        clear_pend();
        do_byte(8'h5A);
        do_stop_wait();
        read_run("R12 counter starts at 0", 0, 1);
    endtask

    // R1 R2 R7: full row write, busy window, readback
    task automatic t_full_row();
        do_load('h0120);
        for (int i = 0; i < 32; i++) do_byte(8'(8'h30 + i * 3));
        for (int i = 0; i < 32; i++) model['h0120 + i] = 8'(8'h30 + i * 3);
        stop_wr_i = 1'b1;
        @(negedge clk); stop_wr_i = 1'b0;
        chk1("R7 busy first cycle", busy_o, 1'b1);
        repeat (WR - 1) @(negedge clk);
        chk1("R7 busy last cycle", busy_o, 1'b1);
        @(negedge clk);
        chk1("R7 busy dropped", busy_o, 1'b0);
        clear_pend();
        read_run("R1 R2 full row readback", 'h0120, 32);
    endtask

    // R2 R3 R6: 34 bytes from offset 30 wrap in the row
    task automatic t_wrap_row();
        do_load('h015E);
        for (int i = 0; i < 34; i++) do_byte(8'(8'hA0 + i));
        do_stop_wait();
        chk8("R6 counter after wrap", rd_data_o, model['h0140]);
        read_run("R3 overwrite on wrap", 'h0140, 32);
    endtask

    // R4: partial row keeps old bytes
    task automatic t_partial();
        do_load('h0125);
        do_byte(8'hE1); do_byte(8'hE2); do_byte(8'hE3);
        do_stop_wait();
        read_run("R4 partial row", 'h0120, 32);
    endtask

    // R5: read advance wraps from top of array to 0
    task automatic t_read_wrap();
        do_load('h1FFE);
        do_byte(8'h71); do_byte(8'h72);
        do_stop_wait();
        read_run("R5 top wrap", 'h1FFE, 3);
        chk8("R5 landed at zero", rd_data_o, 8'h5A);
    endtask

    // R6: counter retained after a write
    task automatic t_retain();
        do_load('h0130);
        do_byte(8'h44);
        do_stop_wait();
        chk8("R6 current read", rd_data_o, model['h0131]);
    endtask

    // R8: write protect
    task automatic t_wp();
        wp_i = 1'b1;
        do_load('h0122);
        do_byte(8'h0F); do_byte(8'hF0);
        stop_wr_i = 1'b1;
        @(negedge clk); stop_wr_i = 1'b0;
        chk1("R8 no busy under wp", busy_o, 1'b0);
        repeat (3) @(negedge clk);
        chk1("R8 still no busy", busy_o, 1'b0);
        wp_i = 1'b0;
        clear_pend();
        chk8("R8 counter advanced", rd_data_o, model['h0124]);
        read_run("R8 row unchanged", 'h0120, 32);
    endtask

    // R9: stop with no data
    task automatic t_empty();
        do_load('h0200);
        stop_wr_i = 1'b1;
        @(negedge clk); stop_wr_i = 1'b0;
        chk1("R9 no busy on empty", busy_o, 1'b0);
        @(negedge clk);
        chk1("R9 still idle", busy_o, 1'b0);
    endtask

    // R11: address load discards buffered bytes
    task automatic t_abandon();
        do_load('h0300); do_byte(8'h11); do_byte(8'h12);
        do_stop_wait();
        do_load('h0300); do_byte(8'hAA);
        do_load('h0301); do_byte(8'hBB);
        do_stop_wait();
        read_run("R11 discard before reload", 'h0300, 2);
    endtask

    // R10: strobes ignored while busy
    task automatic t_busy_ignore();
        do_load('h0400); do_byte(8'h21); do_byte(8'h22);
        do_stop_wait();
        do_load('h0400); do_byte(8'h23);
        stop_wr_i = 1'b1;
        @(negedge clk); stop_wr_i = 1'b0;
        model['h0400] = 8'h23;
        addr_i = AW'('h0410); addr_load_i = 1'b1;
        @(negedge clk); addr_load_i = 1'b0;
        wr_data_i = 8'h99; wr_byte_i = 1'b1;
        @(negedge clk); wr_byte_i = 1'b0;
        rd_adv_i = 1'b1;
        @(negedge clk); rd_adv_i = 1'b0;
        stop_wr_i = 1'b1;
        @(negedge clk); stop_wr_i = 1'b0;
        repeat (WR - 4) @(negedge clk);
        chk1("R10 single busy window", busy_o, 1'b0);
        @(negedge clk);
        chk1("R10 no second window", busy_o, 1'b0);
        clear_pend();
        chk8("R10 counter untouched", rd_data_o, model['h0401]);
        read_run("R10 row after busy", 'h0400, 2);
    endtask

    initial begin
        #(8 * 150000);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_full_row();
        t_wrap_row();
        t_partial();
        t_read_wrap();
        t_retain();
        t_wp();
        t_empty();
        t_abandon();
        t_busy_ignore();
        summary();
    end

endmodule